// File: doc/BRIEF.md
# Wake Input Conditioner

This block takes seven slow wake or control pins from the battery-backed domain and prepares them for a register interface. Each pin goes through a synchroniser. A glitch filter follows, with one enable shared by all pins. Then come a per-pin polarity selection and a per-pin input enable. An optional per-pin capture latch holds an asserted level until software clears it. Two sticky flag words record rising and falling transitions of the conditioned level. Software clears them by bitmap, or clears both words with a single command.

A status word combines the per-pin levels with four side signals: an override input, the state of the output pin, a week alarm and a clock alarm. The side signals pass through the same synchroniser. For each pin, the status shows the captured value when that pin's latch is enabled, and the live conditioned value otherwise. A core-power indication decides which pins may record transitions. While the core rail is on, every enabled pin may record them. While only the battery rail is powered, a separate bitmap selects the pins.

The register port is a single-cycle write strobe with a combinational read of the addressed word.

Top module: `wake_in`

## Requirements
- R1: The status word (address 0) carries pin levels in bits [6:0], the override input in bit 8, the output-pin state in bit 9, the week alarm in bit 16 and the clock alarm in bit 17. All other bits read 0. After reset every configuration register is 0, so the pin bits read 0.
- R2: With the filter disabled (address 1 bit 0 = 0), a change on a pin appears in the status after the third rising clock edge following the change, and not after the second.
- R3: With the filter enabled, a pin's filtered level changes only after the synchronised input has differed from it for FILT_LEN consecutive sample ticks (one tick every TICK_DIV cycles). With FILT_LEN=4 and TICK_DIV=1, a change appears after the sixth edge and not after the fifth. A pulse of 3 cycles is ignored, and a pulse of 4 cycles passes.
- R4: The polarity register (address 3) bit 1 makes a pin active high, and bit 0 makes it active low. Status bit = pin XNOR polarity bit.
- R5: The latch-enable register (address 4) selects capture per pin. A captured bit is set when the conditioned level is asserted, and it holds until a 1 is written to that bit at address 5, which reads 0. The captured word reads at address 6. A latched pin reports the captured bit in status. New captured bits appear only on latch-enabled pins.
- R6: The rising flags (address 7) and falling flags (address 8) are sticky. Writing 1 to a bit at the same address clears it, and writing 0 leaves it unchanged.
- R7: Writing a word with bit 0 = 1 to address 10 clears all rising and falling flags. Address 10 reads 0.
- R8: While core_on = 0, only pins whose bit is set in the battery-edge register (address 9) set transition flags. While core_on = 1, that register has no effect.
- R9: A pin whose input-enable bit (address 2) is 0 reads 0 in the pin level, sets no transition flags and captures nothing.
- R10: The control, input-enable, polarity, latch-enable and battery-edge registers read back the written values, 1 bit and 7 bits wide respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_on | input | 1 | 1 while the core rail is powered |
| pin_in | input | 7 | Raw wake pins |
| ovrd_in | input | 1 | Override input level |
| out_pin_in | input | 1 | Current output pin state |
| week_alarm | input | 1 | Week alarm level |
| rtc_alarm | input | 1 | Clock alarm level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |

## Verification
The bench builds the block with TICK_DIV=1, FILT_LEN=4 and two synchroniser stages. The filter therefore samples every cycle, and its latency boundary falls between the fifth and sixth edge, where a 3- versus 4-cycle pulse can expose it exactly. With that setting the bench sweeps all 128 pin patterns under four polarity words, while the side inputs follow the low pattern bits, so every status bit is checked in both states. Directed cases cover capture and selective release, bitmap and clear-all flag clearing, input gating, and the battery-only edge mask with the core rail off and on.

// File: rtl/wake_in_pkg.sv
package wake_in_pkg;

    localparam int NUM_PINS = 7;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 32;
    localparam int SIDE_W   = 4;

    localparam int ST_OVRD_BIT = 8;
    localparam int ST_OUT_BIT  = 9;
    localparam int ST_WEEK_BIT = 16;
    localparam int ST_RTC_BIT  = 17;

    typedef enum logic [ADDR_W-1:0] {
        REG_STATUS    = 4'd0,
        REG_CTRL      = 4'd1,
        REG_IN_EN     = 4'd2,
        REG_POL       = 4'd3,
        REG_LATCH_EN  = 4'd4,
        REG_LATCH_RST = 4'd5,
        REG_LATCHED   = 4'd6,
        REG_RISE      = 4'd7,
        REG_FALL      = 4'd8,
        REG_BATT_EN   = 4'd9,
        REG_CLR_ALL   = 4'd10
    } reg_addr_e;

    typedef struct packed {
        logic ovrd;
        logic out_pin;
        logic week;
        logic rtc;
    } side_bits_t;

    typedef struct packed {
        logic                filt_en;
        logic [NUM_PINS-1:0] in_en;
        logic [NUM_PINS-1:0] pol;
        logic [NUM_PINS-1:0] latch_en;
        logic [NUM_PINS-1:0] batt_en;
    } cfg_t;

    typedef struct packed {
        logic [NUM_PINS-1:0] latch_rst;
        logic [NUM_PINS-1:0] rise_clr;
        logic [NUM_PINS-1:0] fall_clr;
    } clr_t;

    // polarity bit 1 = active high, 0 = active low
    function automatic logic [NUM_PINS-1:0] apply_pol(
        input logic [NUM_PINS-1:0] lvl,
        input logic [NUM_PINS-1:0] pol
    );
        return ~(lvl ^ pol);
    endfunction

    function automatic logic [DATA_W-1:0] pack_status(
        input logic [NUM_PINS-1:0] pins,
        input side_bits_t          side
    );
        logic [DATA_W-1:0] w;
        w              = '0;
        w[NUM_PINS-1:0] = pins;
        w[ST_OVRD_BIT] = side.ovrd;
        w[ST_OUT_BIT]  = side.out_pin;
        w[ST_WEEK_BIT] = side.week;
        w[ST_RTC_BIT]  = side.rtc;
        return w;
    endfunction

endpackage

// File: rtl/wake_in_sync.sv
module wake_in_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/wake_in_filter.sv
module wake_in_filter #(
    parameter int W        = 7,
    parameter int FILT_LEN = 4,
    parameter int TICK_DIV = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int CNT_W  = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
    localparam int TICK_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic tick;

    generate
        if (TICK_DIV > 1) begin : g_div
            logic [TICK_W-1:0] div_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    div_q <= '0;
                end else if (div_q == TICK_W'(TICK_DIV-1)) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end
            assign tick = (div_q == TICK_W'(TICK_DIV-1));
        end else begin : g_nodiv
            assign tick = 1'b1;
        end
    endgenerate

    generate
        for (genvar g = 0; g < W; g++) begin : g_pin
            logic             lvl_q;
            logic [CNT_W-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    lvl_q <= 1'b0;
                    cnt_q <= '0;
                end else if (!en) begin
                    lvl_q <= d[g];
                    cnt_q <= '0;
                end else if (tick) begin
                    if (d[g] == lvl_q) begin
                        cnt_q <= '0;
                    end else if (cnt_q == CNT_W'(FILT_LEN-1)) begin
                        lvl_q <= d[g];
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end
            assign q[g] = lvl_q;
        end
    endgenerate
endmodule

// File: rtl/wake_in_pin_ctl.sv
module wake_in_pin_ctl
    import wake_in_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                core_on,
    input  logic [NUM_PINS-1:0] filt,
    input  cfg_t                cfg,
    input  clr_t                clr,
    output logic [NUM_PINS-1:0] live,
    output logic [NUM_PINS-1:0] latched,
    output logic [NUM_PINS-1:0] rise,
    output logic [NUM_PINS-1:0] fall
);
    logic [NUM_PINS-1:0] act;
    logic [NUM_PINS-1:0] act_d;
    logic [NUM_PINS-1:0] edge_en;

    always_comb begin
        act     = apply_pol(filt, cfg.pol) & cfg.in_en;
        edge_en = core_on ? {NUM_PINS{1'b1}} : cfg.batt_en;
        live    = (latched & cfg.latch_en) | (act & ~cfg.latch_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_d   <= '0;
            latched <= '0;
            rise    <= '0;
            fall    <= '0;
        end else begin
            act_d   <= act;
            latched <= (latched | (act & cfg.latch_en)) & ~clr.latch_rst;
            rise    <= (rise & ~clr.rise_clr) | (act & ~act_d & edge_en);
            fall    <= (fall & ~clr.fall_clr) | (~act & act_d & edge_en);
        end
    end
endmodule

// File: rtl/wake_in_regs.sv
module wake_in_regs
    import wake_in_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W-1:0]   status,
    input  logic [NUM_PINS-1:0] latched,
    input  logic [NUM_PINS-1:0] rise,
    input  logic [NUM_PINS-1:0] fall,
    output cfg_t                cfg,
    output clr_t                clr,
    output logic [DATA_W-1:0]   rdata
);
    reg_addr_e           sel;
    logic [NUM_PINS-1:0] wpins;
    logic                clr_all;
    logic                unused_hi;

    assign sel       = reg_addr_e'(addr);
    assign wpins     = wdata[NUM_PINS-1:0];
    assign unused_hi = ^wdata[DATA_W-1:NUM_PINS];
    assign clr_all   = wr && (sel == REG_CLR_ALL) && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr) begin
            case (sel)
                REG_CTRL:     cfg.filt_en  <= wdata[0];
                REG_IN_EN:    cfg.in_en    <= wpins;
                REG_POL:      cfg.pol      <= wpins;
                REG_LATCH_EN: cfg.latch_en <= wpins;
                REG_BATT_EN:  cfg.batt_en  <= wpins;
                default: ;
            endcase
        end
    end

    always_comb begin
        clr.latch_rst = (wr && sel == REG_LATCH_RST) ? wpins : '0;
        clr.rise_clr  = clr_all ? {NUM_PINS{1'b1}} :
                        ((wr && sel == REG_RISE) ? wpins : '0);
        clr.fall_clr  = clr_all ? {NUM_PINS{1'b1}} :
                        ((wr && sel == REG_FALL) ? wpins : '0);
    end

    always_comb begin
        rdata = '0;
        case (sel)
            REG_STATUS:   rdata = status;
            REG_CTRL:     rdata[0] = cfg.filt_en;
            REG_IN_EN:    rdata[NUM_PINS-1:0] = cfg.in_en;
            REG_POL:      rdata[NUM_PINS-1:0] = cfg.pol;
            REG_LATCH_EN: rdata[NUM_PINS-1:0] = cfg.latch_en;
            REG_LATCHED:  rdata[NUM_PINS-1:0] = latched;
            REG_RISE:     rdata[NUM_PINS-1:0] = rise;
            REG_FALL:     rdata[NUM_PINS-1:0] = fall;
            REG_BATT_EN:  rdata[NUM_PINS-1:0] = cfg.batt_en;
            default:      rdata = '0;
        endcase
    end
endmodule

// File: rtl/wake_in.sv
module wake_in
    import wake_in_pkg::*;
#(
    parameter int TICK_DIV    = 32,
    parameter int FILT_LEN    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                core_on,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                ovrd_in,
    input  logic                out_pin_in,
    input  logic                week_alarm,
    input  logic                rtc_alarm,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata
);
    localparam int SYNC_W = NUM_PINS + SIDE_W;

    logic [SYNC_W-1:0]   sync_q;
    logic [NUM_PINS-1:0] pin_sync;
    side_bits_t          side_sync;
    logic [NUM_PINS-1:0] pin_filt;
    logic [NUM_PINS-1:0] pin_live;
    logic [NUM_PINS-1:0] latched;
    logic [NUM_PINS-1:0] rise;
    logic [NUM_PINS-1:0] fall;
    logic [DATA_W-1:0]   status;
    cfg_t                cfg;
    clr_t                clr;

    wake_in_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ovrd_in, out_pin_in, week_alarm, rtc_alarm, pin_in}),
        .q   (sync_q)
    );

    assign pin_sync  = sync_q[NUM_PINS-1:0];
    assign side_sync = side_bits_t'(sync_q[SYNC_W-1:NUM_PINS]);

    wake_in_filter #(.W(NUM_PINS), .FILT_LEN(FILT_LEN), .TICK_DIV(TICK_DIV)) u_filt (
        .clk (clk),
        .rst (rst),
        .en  (cfg.filt_en),
        .d   (pin_sync),
        .q   (pin_filt)
    );

    wake_in_pin_ctl u_ctl (
        .clk     (clk),
        .rst     (rst),
        .core_on (core_on),
        .filt    (pin_filt),
        .cfg     (cfg),
        .clr     (clr),
        .live    (pin_live),
        .latched (latched),
        .rise    (rise),
        .fall    (fall)
    );

    assign status = pack_status(pin_live, side_sync);

    wake_in_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .status  (status),
        .latched (latched),
        .rise    (rise),
        .fall    (fall),
        .cfg     (cfg),
        .clr     (clr),
        .rdata   (reg_rdata)
    );
endmodule

// File: rtl/wake_in_chk.sv
module wake_in_chk
    import wake_in_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                core_on,
    input logic                reg_wr,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [DATA_W-1:0]   reg_wdata,
    input logic [DATA_W-1:0]   reg_rdata,
    input cfg_t                cfg,
    input logic [NUM_PINS-1:0] latched,
    input logic [NUM_PINS-1:0] rise,
    input logic [NUM_PINS-1:0] fall
);
    logic [NUM_PINS-1:0] rise_m, fall_m, lrst_m;
    logic                all_m;
    logic                unused_chk;

    assign unused_chk = ^{reg_wdata[DATA_W-1:NUM_PINS], cfg.filt_en, cfg.in_en, cfg.pol};
    assign all_m  = reg_wr && (reg_addr == REG_CLR_ALL) && reg_wdata[0];
    assign rise_m = all_m ? '1 : ((reg_wr && reg_addr == REG_RISE) ? reg_wdata[NUM_PINS-1:0] : '0);
    assign fall_m = all_m ? '1 : ((reg_wr && reg_addr == REG_FALL) ? reg_wdata[NUM_PINS-1:0] : '0);
    assign lrst_m = (reg_wr && reg_addr == REG_LATCH_RST) ? reg_wdata[NUM_PINS-1:0] : '0;

    // R1: reserved status bits stay zero
    p_status_pad_r1: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == REG_STATUS) |-> ((reg_rdata & ~32'h0003_037F) == 32'h0));

    // R6: rising flags hold unless cleared
    p_rise_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((rise & $past(rise & ~rise_m)) == $past(rise & ~rise_m)));

    // R6: falling flags hold unless cleared
    p_fall_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((fall & $past(fall & ~fall_m)) == $past(fall & ~fall_m)));

    // R5: captured bits hold until released
    p_latch_hold_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((latched & $past(latched & ~lrst_m)) == $past(latched & ~lrst_m)));

    // R5: new captures only on latch-enabled pins
    p_latch_gate_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((latched & ~$past(latched) & ~$past(cfg.latch_en)) == '0));

    // R8: battery-only mask on new rising flags
    p_batt_gate_r8: assert property (@(posedge clk) disable iff (rst)
        !core_on |=> ((rise & ~$past(rise) & ~$past(cfg.batt_en)) == '0));
endmodule

bind wake_in wake_in_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .core_on   (core_on),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cfg       (cfg),
    .latched   (latched),
    .rise      (rise),
    .fall      (fall)
);

// File: tb/wake_in_tb.sv
`timescale 1ns/1ps
module wake_in_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        core_on = 1'b1;
    logic [6:0]  pin_in = '0;
    logic        ovrd_in = 1'b0, out_pin_in = 1'b0, week_alarm = 1'b0, rtc_alarm = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    wake_in #(.TICK_DIV(1), .FILT_LEN(4), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .core_on(core_on), .pin_in(pin_in),
        .ovrd_in(ovrd_in), .out_pin_in(out_pin_in), .week_alarm(week_alarm),
        .rtc_alarm(rtc_alarm), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pins(input logic [6:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    initial begin
        #1600000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [31:0] e;
        logic [6:0]  pols [4];
        pols[0] = 7'h7F; pols[1] = 7'h00; pols[2] = 7'h55; pols[3] = 7'h2A;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(4'd2, r); chk("R1 in_en reset", r, 32'h0);
        rd(4'd0, r); chk("R1 status reset", r, 32'h0);
        rd(4'd7, r); chk("R1 rise reset", r, 32'h0);

        // R10 readback
        wr(4'd1, 32'hFFFF_FFFF); rd(4'd1, r); chk("R10 ctrl", r, 32'h1);
        wr(4'd1, 32'h0);
        wr(4'd3, 32'hFFFF_FF2A); rd(4'd3, r); chk("R10 pol", r, 32'h2A);
        wr(4'd4, 32'h55);        rd(4'd4, r); chk("R10 latch_en", r, 32'h55);
        wr(4'd9, 32'h13);        rd(4'd9, r); chk("R10 batt_en", r, 32'h13);
        wr(4'd4, 32'h0); wr(4'd9, 32'h0);
        rd(4'd5, r); chk("R5 latch_rst reads 0", r, 32'h0);
        rd(4'd10, r); chk("R7 clr_all reads 0", r, 32'h0);

        // R4/R1 exhaustive sweep, filter off
        wr(4'd2, 32'h7F);
        foreach (pols[p]) begin
            wr(4'd3, {25'd0, pols[p]});
            reg_addr = 4'd0;
            for (int v = 0; v < 128; v++) begin
                @(negedge clk);
                pin_in = v[6:0];
                ovrd_in = v[0]; out_pin_in = v[1]; week_alarm = v[2]; rtc_alarm = v[3];
                repeat (4) @(negedge clk);
                #1;
                e = {14'd0, v[3], v[2], 6'd0, v[1], v[0], 1'b0, ~(v[6:0] ^ pols[p])};
                chk("R4 R1 status sweep", reg_rdata, e);
            end
        end
        ovrd_in = 1'b0; out_pin_in = 1'b0; week_alarm = 1'b0; rtc_alarm = 1'b0;

        // R2 latency, filter off
        wr(4'd3, 32'h7F);
        set_pins(7'h00); idle(5);
        reg_addr = 4'd0;
        @(negedge clk); pin_in = 7'h01;
        repeat (2) @(posedge clk); #2;
        chk("R2 not after 2nd edge", reg_rdata, 32'h0);
        @(posedge clk); #2;
        chk("R2 after 3rd edge", reg_rdata, 32'h1);

        // R3 filter on
        set_pins(7'h00); idle(5);
        wr(4'd1, 32'h1); idle(3);
        reg_addr = 4'd0;
        @(negedge clk); pin_in = 7'h02;
        repeat (5) @(posedge clk); #2;
        chk("R3 not after 5th edge", reg_rdata, 32'h0);
        @(posedge clk); #2;
        chk("R3 after 6th edge", reg_rdata, 32'h2);
        set_pins(7'h00); idle(10);
        wr(4'd10, 32'h1);
        @(negedge clk); pin_in = 7'h04;
        idle(3); pin_in = 7'h00;        // 3-cycle pulse
        idle(10);
        rd(4'd7, r); chk("R3 3-cycle pulse ignored", r, 32'h0);
        @(negedge clk); pin_in = 7'h04;
        idle(4); pin_in = 7'h00;        // 4-cycle pulse
        idle(10);
        rd(4'd7, r); chk("R3 4-cycle pulse passes", r, 32'h4);
        wr(4'd1, 32'h0);

        // R6/R7 flags
        set_pins(7'h00); idle(5);
        wr(4'd10, 32'h1);
        set_pins(7'h0F); idle(6); set_pins(7'h00); idle(6);
        rd(4'd7, r); chk("R6 rise set", r, 32'h0F);
        rd(4'd8, r); chk("R6 fall set", r, 32'h0F);
        wr(4'd7, 32'h05);
        rd(4'd7, r); chk("R6 rise bitmap clear", r, 32'h0A);
        rd(4'd8, r); chk("R6 fall untouched", r, 32'h0F);
        wr(4'd8, 32'h00);
        rd(4'd8, r); chk("R6 write 0 no effect", r, 32'h0F);
        wr(4'd10, 32'h0);
        rd(4'd7, r); chk("R7 bit0 clear no effect", r, 32'h0A);
        wr(4'd10, 32'h1);
        rd(4'd7, r); chk("R7 clear all rise", r, 32'h0);
        rd(4'd8, r); chk("R7 clear all fall", r, 32'h0);

        // R9 input gating
        wr(4'd2, 32'h0F); idle(4); wr(4'd10, 32'h1);
        set_pins(7'h7F); idle(6);
        rd(4'd0, r); chk("R9 disabled pins read 0", r, 32'h0F);
        set_pins(7'h00); idle(6);
        rd(4'd7, r); chk("R9 rise only enabled", r, 32'h0F);
        wr(4'd4, 32'h70); set_pins(7'h7F); idle(6); set_pins(7'h00); idle(6);
        rd(4'd6, r); chk("R9 no capture when disabled", r, 32'h0);
        wr(4'd4, 32'h0);
        wr(4'd2, 32'h7F); idle(4);

        // R8 battery-only mask
        wr(4'd9, 32'h30); core_on = 1'b0; idle(2);
        wr(4'd10, 32'h1);
        set_pins(7'h7F); idle(6);
        rd(4'd7, r); chk("R8 core off mask", r, 32'h30);
        set_pins(7'h00); idle(6);
        rd(4'd8, r); chk("R8 core off fall mask", r, 32'h30);
        core_on = 1'b1; idle(2);
        wr(4'd10, 32'h1);
        set_pins(7'h7F); idle(6);
        rd(4'd7, r); chk("R8 core on ignores mask", r, 32'h7F);
        set_pins(7'h00); idle(6);

        // R5 latch
        wr(4'd4, 32'h03); wr(4'd5, 32'h7F);
        rd(4'd6, r); chk("R5 latched clear", r, 32'h0);
        set_pins(7'h07); idle(6); set_pins(7'h00); idle(6);
        rd(4'd0, r); chk("R5 status holds latched", r, 32'h03);
        rd(4'd6, r); chk("R5 latched word", r, 32'h03);
        wr(4'd5, 32'h01); idle(1);
        rd(4'd6, r); chk("R5 selective release", r, 32'h02);
        rd(4'd0, r); chk("R5 status after release", r, 32'h02);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule